// File: doc/BRIEF.md
# Memory-Mapped Serial Flash/Card Transfer Engine

This block is a serial master that a processor drives through a small register window. Software loads up to 32 bytes into a data buffer and writes one command word. The engine then clocks 1, 8 or 32 bytes over a single-line or four-line serial link. It keeps a busy flag set until the last bit has moved, and software polls that flag before it issues the next command. Received data lands in the same buffer positions that the outgoing data came from, so one buffer read returns a whole burst.

Each command picks the lane width (one line or four), the direction (full-duplex swap, transmit only, or receive only) and the clocking (one data unit per serial clock or one per clock edge). A divider field in the command word sets the serial clock rate relative to the system clock. The pins are plain QSPI-style signals with output enables. Mapping them to a card socket and framing card commands are left to the surrounding logic.

Top module: `qspi_mmio_ctrl`

## Requirements
- R1: After reset the busy bit (status bit 7) reads 0, `sck` is 0, `dat_o[3]` and `dat_oe[3]` are 1 (chip select idle high), and `cmd_oe` is 1.
- R2: Offsets 0x8, 0x9, 0xA and 0xB read and write the 64-bit buffer words 0 to 3. Offset 0x4 reads and writes bits [7:0] of word 0, and a write there leaves the other bits unchanged. Offset 0x0 reads the divider in bits [31:16], BUSY in bit 7, the fast-clock flag in bit 5, the four-line flag in bit 4 and the receive flag in bit 3.
- R3: A write to offset 0x0 with exactly one of bits 0, 1 or 2 set starts a transfer of 1, 8 or 32 bytes. With none of those bits set, or more than one, no transfer starts, but bits [31:16], 5, 4 and 3 are still stored.
- R4: BUSY reads 1 on the cycle after a starting write. While BUSY is 1, writes to any register are ignored.
- R5: While idle, `sck` stays 0. During a transfer, `sck` has a period of 2*(div+1) system clocks and starts low.
- R6: Single-line swap (bit 4 = 0, bit 3 = 0): bits go out on `cmd_o` most significant bit first, starting with byte 0 of word 0 (byte k of a word is bits [8k+7:8k]). Bits are sampled from `dat_i[0]`, and each received bit replaces the bit sent in the same buffer position.
- R7: Single-line receive (bit 4 = 0, bit 3 = 1): `cmd_oe` is 0 while busy, and bits are sampled from `cmd_i` into the buffer in the R6 order.
- R8: Four-line transmit (bit 4 = 1, bit 3 = 0): `dat_oe` is 4'hF and nibbles go out on `dat_o`, high nibble of each byte first. The buffer is unchanged after the transfer.
- R9: Four-line receive (bit 4 = 1, bit 3 = 1): `dat_oe` is 0 while busy, and nibbles from `dat_i` fill the buffer in the R8 order.
- R10: With bit 5 = 1, a unit moves on both clock edges, so a transfer needs half as many `sck` rising edges as with bit 5 = 0. The unit is a bit in single-line mode and a nibble in four-line mode.
- R11: In single-line mode `dat_o[3]` is a chip select. It is low with `dat_oe[3]` = 1 for the whole transfer and high whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr` (combinational) |
| sck | output | 1 | Serial clock |
| cmd_o | output | 1 | Command/MOSI line output |
| cmd_oe | output | 1 | Command line output enable |
| cmd_i | input | 1 | Command line input |
| dat_o | output | 4 | Data lines 0..3 output |
| dat_oe | output | 4 | Data lines output enables |
| dat_i | input | 4 | Data lines input |

## Verification
The assertions check the pin rules that hold on every cycle:
- the serial clock is quiet and chip select is high when idle;
- the lines are released only while busy;
- the clock moves only during a transfer;
- busy rises only after a control write.

Only the bench scenarios can show the rest. A slave model in the bench answers every sampling edge, so it can compare the bit and nibble order on the wire, the clock period and edge counts for each divider and rate, and the received data as it appears in the buffer. It also covers the rejected size codes and the writes ignored during a burst, whose effects only appear through register reads afterwards.

// File: rtl/qmc_pkg.sv
package qmc_pkg;
    localparam int unsigned CTL_SZ1  = 0;
    localparam int unsigned CTL_SZ8  = 1;
    localparam int unsigned CTL_SZ32 = 2;
    localparam int unsigned CTL_RX   = 3;
    localparam int unsigned CTL_QUAD = 4;
    localparam int unsigned CTL_DUAL = 5;
    localparam int unsigned CTL_BUSY = 7;
    localparam int unsigned CTL_DIV  = 16;

    typedef enum logic [1:0] {
        LN_SPI_SWAP = 2'b00,
        LN_SPI_RECV = 2'b01,
        LN_QD_SEND  = 2'b10,
        LN_QD_RECV  = 2'b11
    } lane_mode_e;
endpackage

// File: rtl/qmc_clkgen.sv
module qmc_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = run && (cnt_q == div);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/qmc_lane.sv
module qmc_lane
    import qmc_pkg::*;
(
    input  logic       busy,
    input  lane_mode_e mode,
    input  logic [3:0] unit_out,
    input  logic       cmd_i,
    input  logic [3:0] dat_i,
    output logic       cmd_o,
    output logic       cmd_oe,
    output logic [3:0] dat_o,
    output logic [3:0] dat_oe,
    output logic [3:0] unit_in
);
    always_comb begin
        cmd_o   = 1'b0;
        cmd_oe  = 1'b1;
        dat_o   = 4'b1000;
        dat_oe  = 4'b1000;
        unit_in = {3'b000, dat_i[0]};
        if (busy) begin
            unique case (mode)
                LN_SPI_SWAP: begin
                    cmd_o = unit_out[0];
                    dat_o = 4'b0000;
                end
                LN_SPI_RECV: begin
                    cmd_oe  = 1'b0;
                    dat_o   = 4'b0000;
                    unit_in = {3'b000, cmd_i};
                end
                LN_QD_SEND: begin
                    dat_o  = unit_out;
                    dat_oe = 4'b1111;
                end
                LN_QD_RECV: begin
                    dat_o   = 4'b0000;
                    dat_oe  = 4'b0000;
                    unit_in = dat_i;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/qspi_mmio_ctrl.sv
module qspi_mmio_ctrl
    import qmc_pkg::*;
#(
    parameter int BUF_BYTES = 32,
    parameter int DIV_W     = 16,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sck,
    output logic              cmd_o,
    output logic              cmd_oe,
    input  logic              cmd_i,
    output logic [3:0]        dat_o,
    output logic [3:0]        dat_oe,
    input  logic [3:0]        dat_i
);
    localparam int BUF_W  = BUF_BYTES * 8;
    localparam int WORDS  = BUF_W / DATA_W;
    localparam int WBYTES = DATA_W / 8;
    localparam int POS_W  = $clog2(BUF_W);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_BYTE  = ADDR_W'(4);
    localparam int                A_WORD0 = 8;

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic             rx;
        logic             quad;
        logic             dual;
        logic [DIV_W-1:0] div;
        logic [POS_W-1:0] pos;
        logic [POS_W-1:0] last;
        logic [3:0]       out;
        logic [BUF_W-1:0] data;
    } state_t;

    state_t q, d;
    logic       tick;
    logic [3:0] unit_in;
    logic       busy_w;

    function automatic logic [POS_W-1:0] unit_base(input logic [POS_W-1:0] pos, input logic quad);
        int p;
        p = int'(pos);
        if (quad) return POS_W'((p / 2) * 8 + ((p % 2 == 1) ? 0 : 4));
        else      return POS_W'((p / 8) * 8 + 7 - (p % 8));
    endfunction

    function automatic logic [3:0] unit_get(input logic [BUF_W-1:0] buf_v,
                                            input logic [POS_W-1:0] pos, input logic quad);
        logic [POS_W-1:0] b;
        b = unit_base(pos, quad);
        if (quad) return buf_v[b +: 4];
        else      return {3'b000, buf_v[b]};
    endfunction

    function automatic logic [BUF_W-1:0] unit_put(input logic [BUF_W-1:0] buf_v,
                                                  input logic [POS_W-1:0] pos, input logic quad,
                                                  input logic [3:0] val);
        logic [BUF_W-1:0] r;
        logic [POS_W-1:0] b;
        r = buf_v;
        b = unit_base(pos, quad);
        if (quad) r[b +: 4] = val;
        else      r[b] = val[0];
        return r;
    endfunction

    function automatic logic [POS_W-1:0] unit_last(input logic [2:0] sz, input logic quad);
        int nb;
        nb = sz[CTL_SZ1] ? 1 : (sz[CTL_SZ8] ? WBYTES : BUF_BYTES);
        return POS_W'((quad ? nb * 2 : nb * 8) - 1);
    endfunction

    qmc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (q.busy),
        .div  (q.div),
        .tick (tick)
    );

    qmc_lane u_lane (
        .busy    (q.busy),
        .mode    (lane_mode_e'({q.quad, q.rx})),
        .unit_out(q.out),
        .cmd_i   (cmd_i),
        .dat_i   (dat_i),
        .cmd_o   (cmd_o),
        .cmd_oe  (cmd_oe),
        .dat_o   (dat_o),
        .dat_oe  (dat_oe),
        .unit_in (unit_in)
    );

    always_comb begin
        logic       wr;
        logic [2:0] sz;
        logic       nq;
        d  = q;
        wr = bus_sel && bus_we && !q.busy;
        sz = bus_wdata[2:0];
        nq = bus_wdata[CTL_QUAD];
        if (wr) begin
            if (bus_addr == A_CTRL) begin
                d.div  = bus_wdata[CTL_DIV +: DIV_W];
                d.rx   = bus_wdata[CTL_RX];
                d.quad = nq;
                d.dual = bus_wdata[CTL_DUAL];
                if ($onehot(sz)) begin
                    d.busy = 1'b1;
                    d.sck  = 1'b0;
                    d.pos  = '0;
                    d.last = unit_last(sz, nq);
                    d.out  = unit_get(q.data, '0, nq);
                end
            end else if (bus_addr == A_BYTE) begin
                d.data[7:0] = bus_wdata[7:0];
            end else begin
                for (int k = 0; k < WORDS; k++) begin
                    if (bus_addr == ADDR_W'(A_WORD0 + k))
                        d.data[k*DATA_W +: DATA_W] = bus_wdata;
                end
            end
        end
        if (q.busy && tick) begin
            if ((!q.sck || q.dual) && !(q.quad && !q.rx))
                d.data = unit_put(q.data, q.pos, q.quad, unit_in);
            d.sck = !q.sck;
            if (q.sck || q.dual) begin
                if (q.pos == q.last) begin
                    d.busy = 1'b0;
                    d.sck  = 1'b0;
                end else begin
                    d.pos = q.pos + 1'b1;
                    d.out = unit_get(d.data, q.pos + 1'b1, q.quad);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[CTL_DIV +: DIV_W] = q.div;
            bus_rdata[CTL_BUSY]         = q.busy;
            bus_rdata[CTL_DUAL]         = q.dual;
            bus_rdata[CTL_QUAD]         = q.quad;
            bus_rdata[CTL_RX]           = q.rx;
        end else if (bus_addr == A_BYTE) begin
            bus_rdata[7:0] = q.data[7:0];
        end else begin
            for (int k = 0; k < WORDS; k++) begin
                if (bus_addr == ADDR_W'(A_WORD0 + k))
                    bus_rdata = q.data[k*DATA_W +: DATA_W];
            end
        end
    end

    assign sck    = q.sck;
    assign busy_w = q.busy;
endmodule

// File: rtl/qmc_chk.sv
module qmc_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              sck,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              cmd_oe,
    input logic [3:0]        dat_o,
    input logic [3:0]        dat_oe
);
    // R5
    idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);
    // R5
    sck_moves_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sck) |-> $past(busy));
    // R11
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dat_oe[3] && dat_o[3]));
    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_sel && bus_we && bus_addr == '0));
    // R7
    cmd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> busy);
    // R9
    data_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_oe == 4'b0000) |-> busy);
endmodule

bind qspi_mmio_ctrl qmc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_w),
    .sck     (sck),
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .cmd_oe  (cmd_oe),
    .dat_o   (dat_o),
    .dat_oe  (dat_oe)
);

// File: tb/tb_qspi_mmio_ctrl.sv
`timescale 1ns/1ps
module tb_qspi_mmio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        sck, cmd_o, cmd_oe;
    logic        cmd_i = 1'b0;
    logic [3:0]  dat_o, dat_oe;
    logic [3:0]  dat_i = '0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    qspi_mmio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_i),
        .dat_o(dat_o), .dat_oe(dat_oe), .dat_i(dat_i)
    );

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [63:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 4'h0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [63:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // Wire order: MSB of byte 0 first; nibble mode sends the high nibble first.
    function automatic int lsb_of(input int i, input logic quad);
        if (quad) return (i / 2) * 8 + ((i % 2 == 0) ? 4 : 0);
        return (i / 8) * 8 + (7 - i % 8);
    endfunction

    function automatic logic [3:0] pick(input logic [255:0] b, input int i, input logic quad);
        int at;
        at = lsb_of(i, quad);
        if (quad) return b[at +: 4];
        return {3'b000, b[at]};
    endfunction

    task automatic drive_rx(input logic [255:0] rxb, input int i, input logic quad, input logic rx);
        logic [3:0] v;
        v = pick(rxb, i, quad);
        if (quad) dat_i = v;
        else if (rx) cmd_i = v[0];
        else dat_i = {3'b000, v[0]};
    endtask

    task automatic run_xfer(input logic [2:0] sz, input logic rx, input logic quad,
                            input logic dual, input logic [15:0] div);
        logic [255:0] txb, rxb, expb;
        logic [3:0]   txu [256];
        logic [63:0]  v;
        logic         prev_sck, prev_cmd;
        logic [3:0]   prev_dat;
        logic         per_ok, pin_ok;
        int           nbytes, units, n, rises, cyc, last_rise;
        string        tag;
        nbytes = sz[0] ? 1 : (sz[1] ? 8 : 32);
        units  = quad ? nbytes * 2 : nbytes * 8;
        tag    = quad ? (rx ? "R9" : "R8") : (rx ? "R7" : "R6");
        for (int k = 0; k < 8; k++) begin
            txb[k*32 +: 32] = $urandom;
            rxb[k*32 +: 32] = $urandom;
        end
        for (int k = 0; k < 4; k++) bus_wr(4'(8 + k), txb[k*64 +: 64]);
        dat_i = '0; cmd_i = 1'b0;
        drive_rx(rxb, 0, quad, rx);
        bus_wr(4'h0, {32'h0, div, 8'h0, 2'b00, dual, quad, rx, sz});
        bus_rd(4'h0, v);
        check(v[7] == 1'b1, "R4 busy after start", {63'h0, v[7]}, 64'h1);
        n = 0; rises = 0; cyc = 0; last_rise = 0; per_ok = 1'b1; pin_ok = 1'b1;
        prev_sck = sck; prev_cmd = cmd_o; prev_dat = dat_o;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (sck != prev_sck) begin
                if (sck) begin
                    if (rises > 0 && (cyc - last_rise) != 2 * (int'(div) + 1)) per_ok = 1'b0;
                    last_rise = cyc;
                    rises++;
                end
                if (sck || dual) begin
                    if (n < 256) txu[n] = quad ? prev_dat : {3'b000, prev_cmd};
                    n++;
                    if (n < units) drive_rx(rxb, n, quad, rx);
                end
            end
            if (bus_rdata[7]) begin
                if (!quad && (dat_o[3] != 1'b0 || dat_oe[3] != 1'b1)) pin_ok = 1'b0;
                if (cmd_oe != !(!quad && rx)) pin_ok = 1'b0;
                if (quad && dat_oe != (rx ? 4'h0 : 4'hF)) pin_ok = 1'b0;
            end
            prev_sck = sck; prev_cmd = cmd_o; prev_dat = dat_o;
            if (!bus_rdata[7]) break;
        end
        check(n == units, "R3 unit count", 64'(n), 64'(units));
        check(rises == (dual ? units / 2 : units), "R10 rising edges", 64'(rises), 64'(dual ? units / 2 : units));
        check(per_ok, "R5 sck period", {63'h0, per_ok}, 64'h1);
        check(pin_ok, quad ? tag : "R11 pins during transfer", {63'h0, pin_ok}, 64'h1);
        if (!rx) begin
            for (int i = 0; i < units; i++)
                if (txu[i] != pick(txb, i, quad)) begin
                    check(1'b0, tag, 64'(txu[i]), 64'(pick(txb, i, quad)));
                    break;
                end
        end
        expb = txb;
        if (!(quad && !rx)) begin
            for (int i = 0; i < units; i++) begin
                if (quad) expb[lsb_of(i, 1'b1) +: 4] = rxb[lsb_of(i, 1'b1) +: 4];
                else      expb[lsb_of(i, 1'b0)] = rxb[lsb_of(i, 1'b0)];
            end
        end
        for (int k = 0; k < 4; k++) begin
            bus_rd(4'(8 + k), v);
            check(v == expb[k*64 +: 64], tag, v, expb[k*64 +: 64]);
        end
        bus_addr = 4'h0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        bus_rd(4'h0, v);
        check(v[7] == 1'b0, "R1 busy", v, 64'h0);
        check(sck == 1'b0 && cmd_oe == 1'b1, "R1 sck/cmd_oe", {62'h0, sck, cmd_oe}, 64'h1);
        check(dat_o[3] && dat_oe[3], "R1 cs idle", {60'h0, dat_o}, 64'h8);

        // R2 register window
        for (int k = 0; k < 4; k++) bus_wr(4'(8 + k), 64'h0123_4567_89AB_CDEF ^ 64'(k * 32'h1111));
        for (int k = 0; k < 4; k++) begin
            bus_rd(4'(8 + k), v);
            check(v == (64'h0123_4567_89AB_CDEF ^ 64'(k * 32'h1111)), "R2 word", v,
                  64'h0123_4567_89AB_CDEF ^ 64'(k * 32'h1111));
        end
        bus_wr(4'h4, 64'hFFFF_FFFF_FFFF_FF5A);
        bus_rd(4'h8, v);
        check(v == 64'h0123_4567_89AB_CD5A, "R2 byte alias", v, 64'h0123_4567_89AB_CD5A);
        bus_rd(4'h4, v);
        check(v == 64'h5A, "R2 byte read", v, 64'h5A);

        // R3 bad size codes: config stored, no transfer
        bus_wr(4'h0, {32'h0, 16'h0005, 8'h0, 8'b0011_1011});
        bus_rd(4'h0, v);
        check(v[7] == 1'b0, "R3 two size bits", v, 64'h0);
        check(v[31:16] == 16'h5 && v[5:3] == 3'b111, "R3 config stored", v, 64'h0005_0038);
        bus_wr(4'h0, {32'h0, 16'h0002, 8'h0, 8'b0000_1000});
        repeat (4) @(negedge clk);
        bus_rd(4'h0, v);
        check(v[7] == 1'b0 && sck == 1'b0, "R3 no size bit", v, 64'h0002_0008);

        // directed transfers in each mode
        run_xfer(3'b001, 1'b0, 1'b0, 1'b0, 16'd0);   // R6
        run_xfer(3'b010, 1'b1, 1'b0, 1'b0, 16'd1);   // R7
        run_xfer(3'b100, 1'b0, 1'b1, 1'b0, 16'd0);   // R8
        run_xfer(3'b010, 1'b1, 1'b1, 1'b1, 16'd2);   // R9 R10
        run_xfer(3'b001, 1'b0, 1'b0, 1'b1, 16'd3);   // R10 R11
        run_xfer(3'b100, 1'b1, 1'b0, 1'b1, 16'd0);   // R10

        // R4 writes ignored while busy
        bus_wr(4'hB, 64'hCAFE_F00D_0000_1111);
        dat_i = '0;
        bus_wr(4'h0, {32'h0, 16'h0003, 8'h0, 8'b0000_0010});
        repeat (5) @(negedge clk);
        bus_wr(4'h0, {32'h0, 16'h0009, 8'h0, 8'b0001_0001});
        bus_wr(4'hB, 64'hDEAD_BEEF_DEAD_BEEF);
        do @(negedge clk); while (bus_rdata[7]);
        repeat (3) @(negedge clk);
        bus_rd(4'h0, v);
        check(v[31:16] == 16'h3 && v[7] == 1'b0 && v[4] == 1'b0, "R4 ctrl ignored", v, 64'h0003_0000);
        bus_rd(4'hB, v);
        check(v == 64'hCAFE_F00D_0000_1111, "R4 data ignored", v, 64'hCAFE_F00D_0000_1111);
        bus_addr = 4'h0;

        // constrained random mix
        for (int t = 0; t < 10; t++) begin
            logic [2:0] sz;
            sz = 3'b001 << ($urandom % 3);
            run_xfer(sz, 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom % 3));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule